// File: doc/BRIEF.md
# Synchronous DRAM Read Output Latency Pipeline

This block produces the read data bus timing of a synchronous DRAM that has a 32-bit data bus split into four byte lanes. A read command starts a burst. The burst length comes from a three-bit mode code that comes with the command. The block takes one beat of array data per cycle while the burst runs, and delays each beat by the programmed CAS latency of 1, 2 or 3 clocks. It then drives the beat onto the bus, together with a per-lane output enable. A lane whose enable is low stands for high impedance, and its data bits read as zero.

Byte masks act on reads with a fixed two-clock latency. A new read can cut into a running read with no gap on the bus. A precharge or a write stops a running burst from being issued further, while beats already in the latency pipeline drain normally. When a write cuts into a read, the block checks two conditions. One is the two-clock mask lead before the write. The other is the one-cycle high-impedance gap before the write. Each failure raises its own one-cycle flag.

Top module: `sdr_rd_out_pipe`

## Requirements
- R1: With latency code `cas_lat_i` of 1, 2 or 3 (code 0 acts as 3), a beat issued in cycle c is driven on the bus in cycle c+latency.
- R2: A read command issues its first beat in its own cycle and the next beats in consecutive cycles. Each beat carries the `rd_data_i` value of its issue cycle. The length code `bl_code_i` gives the number of beats: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 4 to 6 give 1. Code 7 means full page: beats continue until the burst is interrupted.
- R3: In a cycle with no beat on the bus, `dq_oe_o` is 0 and `dq_o` is 0. Data bits of a disabled lane read 0.
- R4: If `dqm_i[b]` is high in cycle c, lane b (bits 8b+7:8b) is disabled in cycle c+2.
- R5: A read command during a burst restarts issue with the new length from that cycle. The new data follows the old data on the bus with no idle cycle.
- R6: A precharge strobe with no read command stops issue from its own cycle onward. Beats issued before it still reach the bus.
- R7: A write strobe stops issue in the same way as a precharge, and `dq_oe_o` is 0 in the write cycle.
- R8: `viol_mask_o` pulses in cycle W+1 after a write in cycle W if a beat was issued in the last latency cycles before W and `dqm_i` in cycle W-2 was not all ones.
- R9: `viol_gap_o` pulses in cycle W+1 after a write in cycle W if `dq_oe_o` was nonzero in cycle W-1, or if an unmasked beat would have driven in cycle W.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cas_lat_i | input | 2 | Read latency code |
| rd_cmd_i | input | 1 | Read command strobe |
| bl_code_i | input | 3 | Burst length code for the read |
| rd_data_i | input | 32 | Array data for the beat issued this cycle |
| dqm_i | input | 4 | Per-lane read mask |
| wr_cmd_i | input | 1 | Write command strobe |
| pre_cmd_i | input | 1 | Precharge command strobe |
| dq_o | output | 32 | Data bus value |
| dq_oe_o | output | 4 | Per-lane output enable |
| viol_mask_o | output | 1 | Missing mask lead before a write |
| viol_gap_o | output | 1 | Missing high-impedance gap before a write |

## Verification
The assertions assume that `cas_lat_i` changes only while no burst is in the pipeline. They also assume that a read command never comes in the same cycle as a write or precharge strobe, and that inputs sit at zero during reset. The stimulus applies reset before every scenario and sets the latency before reset is released. It places commands only on separate cycles, so each scenario sweeps all three latencies under those limits. The scenarios cover every length code, interrupt patterns, and write cases with and without the proper mask lead and gap.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;

  // remaining beats after the first one; reserved codes fall back to single beat
  function automatic logic [2:0] bl_extra(input logic [2:0] code);
    case (code)
      BL_2:    return 3'd1;
      BL_4:    return 3'd3;
      BL_8:    return 3'd7;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/rd_burst_issue.sv
module rd_burst_issue #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MAX_BL = 8,
  localparam int unsigned CNT_W = $clog2(MAX_BL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_cmd_i,
  input  logic [2:0]        bl_code_i,
  input  logic              wr_cmd_i,
  input  logic              pre_cmd_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              issue_o,
  output logic [DATA_W-1:0] issue_data_o
);
  import sdr_rd_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             page_q, page_d;
  logic             stop;

  assign stop         = pre_cmd_i | wr_cmd_i;
  assign issue_o      = rd_cmd_i | ((cnt_q != '0 || page_q) && !stop);
  assign issue_data_o = rd_data_i;

  always_comb begin
    cnt_d  = cnt_q;
    page_d = page_q;
    if (rd_cmd_i) begin
      cnt_d  = CNT_W'(bl_extra(bl_code_i));
      page_d = (bl_code_i == BL_PAGE);
    end else if (stop) begin
      cnt_d  = '0;
      page_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      page_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      page_q <= page_d;
    end
  end

  p_burst_contig_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && !rd_cmd_i && $past(rst_ni)) |-> $past(issue_o));

  p_stop_issue_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_cmd_i && !rd_cmd_i) |=> (!issue_o || rd_cmd_i));
endmodule

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MAX_CL = 3,
  localparam int unsigned SEL_W = $clog2(MAX_CL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  cas_lat_i,
  input  logic              issue_i,
  input  logic [DATA_W-1:0] issue_data_i,
  output logic              beat_vld_o,
  output logic [DATA_W-1:0] beat_data_o,
  output logic              busy_o
);
  logic [MAX_CL-1:0] vld_q;
  logic [DATA_W-1:0] dat_q [MAX_CL];
  int unsigned       sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      dat_q[0] <= '0;
    end else begin
      vld_q[0] <= issue_i;
      dat_q[0] <= issue_data_i;
    end
  end

  for (genvar k = 1; k < MAX_CL; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[k] <= 1'b0;
        dat_q[k] <= '0;
      end else begin
        vld_q[k] <= vld_q[k-1];
        dat_q[k] <= dat_q[k-1];
      end
    end
  end

  // code 0 and codes above MAX_CL select the deepest stage
  always_comb begin
    if (cas_lat_i == '0 || int'(cas_lat_i) > MAX_CL) sel = MAX_CL - 1;
    else                                              sel = int'(cas_lat_i) - 1;
  end

  assign beat_vld_o  = vld_q[sel];
  assign beat_data_o = dat_q[sel];

  // beats still to appear on the bus in this or later cycles
  always_comb begin
    busy_o = 1'b0;
    for (int k = 0; k < MAX_CL; k++)
      if (k <= int'(sel)) busy_o = busy_o | vld_q[k];
  end

  p_cl1_timing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_lat_i == SEL_W'(1) && $past(cas_lat_i) == SEL_W'(1) && $past(issue_i) && $past(rst_ni))
      |-> beat_vld_o);
endmodule

// File: rtl/rd_mask_pipe.sv
module rd_mask_pipe #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned MASK_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] dqm_i,
  output logic [LANES-1:0] mask_o
);
  logic [LANES-1:0] m_q [MASK_LAT];

  for (genvar k = 0; k < MASK_LAT; k++) begin : g_mstage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     m_q[k] <= '0;
      else if (k == 0) m_q[k] <= dqm_i;
      else             m_q[k] <= m_q[(k == 0) ? 0 : k-1];
    end
  end

  assign mask_o = m_q[MASK_LAT-1];
endmodule

// File: rtl/rd_wr_guard.sv
module rd_wr_guard #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cmd_i,
  input  logic             busy_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [LANES-1:0] drive_raw_i,
  input  logic [LANES-1:0] oe_i,
  output logic             viol_mask_o,
  output logic             viol_gap_o
);
  logic oe_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_prev_q   <= 1'b0;
      viol_mask_o <= 1'b0;
      viol_gap_o  <= 1'b0;
    end else begin
      oe_prev_q   <= |oe_i;
      viol_mask_o <= wr_cmd_i & busy_i & ~(&mask_i);
      viol_gap_o  <= wr_cmd_i & (oe_prev_q | (|drive_raw_i));
    end
  end
endmodule

// File: rtl/sdr_rd_out_pipe.sv
module sdr_rd_out_pipe #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned MAX_CL   = 3,
  parameter int unsigned MAX_BL   = 8,
  parameter int unsigned MASK_LAT = 2,
  localparam int unsigned DATA_W  = LANES * sdr_rd_pkg::LANE_W,
  localparam int unsigned SEL_W   = $clog2(MAX_CL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  cas_lat_i,
  input  logic              rd_cmd_i,
  input  logic [2:0]        bl_code_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [LANES-1:0]  dqm_i,
  input  logic              wr_cmd_i,
  input  logic              pre_cmd_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [LANES-1:0]  dq_oe_o,
  output logic              viol_mask_o,
  output logic              viol_gap_o
);
  import sdr_rd_pkg::*;

  logic              issue;
  logic [DATA_W-1:0] issue_data;
  logic              beat_vld;
  logic [DATA_W-1:0] beat_data;
  logic              busy;
  logic [LANES-1:0]  mask;
  logic [LANES-1:0]  drive_raw;

  rd_burst_issue #(.DATA_W(DATA_W), .MAX_BL(MAX_BL)) i_issue (
    .clk_i, .rst_ni, .rd_cmd_i, .bl_code_i, .wr_cmd_i, .pre_cmd_i, .rd_data_i,
    .issue_o(issue), .issue_data_o(issue_data)
  );

  rd_lat_pipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL)) i_lat (
    .clk_i, .rst_ni, .cas_lat_i, .issue_i(issue), .issue_data_i(issue_data),
    .beat_vld_o(beat_vld), .beat_data_o(beat_data), .busy_o(busy)
  );

  rd_mask_pipe #(.LANES(LANES), .MASK_LAT(MASK_LAT)) i_mask (
    .clk_i, .rst_ni, .dqm_i, .mask_o(mask)
  );

  assign drive_raw = {LANES{beat_vld}} & ~mask;
  assign dq_oe_o   = drive_raw & {LANES{~wr_cmd_i}};

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign dq_o[b*LANE_W +: LANE_W] = dq_oe_o[b] ? beat_data[b*LANE_W +: LANE_W] : '0;

    p_mask_blank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(rst_ni, 2) && $past(dqm_i[b], 2)) |-> !dq_oe_o[b]);
  end

  rd_wr_guard #(.LANES(LANES)) i_guard (
    .clk_i, .rst_ni, .wr_cmd_i, .busy_i(busy), .mask_i(mask),
    .drive_raw_i(drive_raw), .oe_i(dq_oe_o),
    .viol_mask_o, .viol_gap_o
  );

  p_no_oe_on_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd_i |-> (dq_oe_o == '0));

  p_gap_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|dq_oe_o) ##1 wr_cmd_i) |=> viol_gap_o);
endmodule

// File: tb/test_sdr_rd_out_pipe.sv
module test_sdr_rd_out_pipe;
  localparam int N = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cas_lat_i = 2'd1;
  logic        rd_cmd_i = 1'b0;
  logic [2:0]  bl_code_i = 3'd0;
  logic [31:0] rd_data_i = '0;
  logic [3:0]  dqm_i = '0;
  logic        wr_cmd_i = 1'b0;
  logic        pre_cmd_i = 1'b0;
  logic [31:0] dq_o;
  logic [3:0]  dq_oe_o;
  logic        viol_mask_o, viol_gap_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sdr_rd_out_pipe i_sdr_rd_out_pipe (.*);

  bit         rd_a [N];
  bit         wr_a [N];
  bit         pr_a [N];
  logic [2:0] bl_a [N];
  logic [3:0] dm_a [N];
  bit         iss  [N];
  logic [3:0] oe_x [N];

  function automatic logic [31:0] dat(int c);
    return 32'(c + 1) * 32'h9E37_79B1;
  endfunction

  function automatic int blen(logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 1000;
      default: return 1;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic build(int sid);
    for (int c = 0; c < N; c++) begin
      rd_a[c] = 0; wr_a[c] = 0; pr_a[c] = 0; bl_a[c] = 3'd0; dm_a[c] = 4'h0;
    end
    case (sid)
      0, 1, 2, 3, 4: begin  // plain bursts, every length code class
        rd_a[2] = 1;
        bl_a[2] = (sid == 4) ? 3'd5 : 3'(sid);
        dm_a[6] = 4'b1010;
      end
      5: begin  // full page stopped by precharge
        rd_a[2] = 1; bl_a[2] = 3'd7; pr_a[14] = 1; dm_a[9] = 4'b0001;
      end
      6: begin  // read interrupts read
        rd_a[2] = 1; bl_a[2] = 3'd3; rd_a[5] = 1; bl_a[5] = 3'd2;
      end
      7: begin  // write after burst drained, mask held high
        rd_a[2] = 1; bl_a[2] = 3'd2;
        for (int c = 8; c <= 10; c++) dm_a[c] = 4'hF;
        wr_a[12] = 1;
      end
      8: begin  // write interrupts with no mask
        rd_a[2] = 1; bl_a[2] = 3'd3; wr_a[6] = 1;
      end
      default: begin  // write interrupts with proper lead and gap
        rd_a[2] = 1; bl_a[2] = 3'd3; wr_a[6] = 1;
        for (int c = 3; c < N; c++) dm_a[c] = 4'hF;
      end
    endcase
  endtask

  task automatic run(int cl, int sid, string tag);
    int rem;
    build(sid);
    rem = 0;
    for (int c = 0; c < N; c++) begin
      if (rd_a[c]) begin
        iss[c] = 1; rem = blen(bl_a[c]) - 1;
      end else if (pr_a[c] || wr_a[c]) begin
        iss[c] = 0; rem = 0;
      end else if (rem > 0) begin
        iss[c] = 1; rem--;
      end else iss[c] = 0;
    end
    for (int c = 0; c < N; c++) begin
      bit v = (c >= cl) && iss[c-cl];
      logic [3:0] m = (c >= 2) ? dm_a[c-2] : 4'h0;
      oe_x[c] = (v && !wr_a[c]) ? ~m : 4'h0;
    end
    rst_ni = 1'b0; rd_cmd_i = 0; wr_cmd_i = 0; pre_cmd_i = 0; dqm_i = '0; bl_code_i = '0;
    cas_lat_i = 2'(cl);
    #3;
    chk(dq_oe_o == 0 && dq_o == 0 && !viol_mask_o && !viol_gap_o, "R10 reset",
        {dq_oe_o, viol_mask_o, viol_gap_o, dq_o[25:0]}, 32'h0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    for (int c = 0; c < N; c++) begin
      logic [31:0] ed;
      bit v;
      logic [3:0] m;
      bit em, eg;
      @(posedge clk_i); #1;
      rd_cmd_i = rd_a[c]; bl_code_i = bl_a[c]; wr_cmd_i = wr_a[c];
      pre_cmd_i = pr_a[c]; dqm_i = dm_a[c]; rd_data_i = dat(c);
      #2;
      ed = '0;
      for (int b = 0; b < 4; b++)
        if (oe_x[c][b]) ed[b*8 +: 8] = dat(c - cl) >> (b * 8);
      chk(dq_oe_o == oe_x[c], {tag, " oe"}, 32'(dq_oe_o), 32'(oe_x[c]));
      chk(dq_o == ed, {tag, " dq"}, dq_o, ed);
      em = 0; eg = 0;
      if (c >= 1 && wr_a[c-1]) begin
        int w = c - 1;
        bit busy = 0;
        for (int k = w - cl; k < w; k++) if (k >= 0 && iss[k]) busy = 1;
        v = (w >= cl) && iss[w-cl];
        m = (w >= 2) ? dm_a[w-2] : 4'h0;
        em = busy && (m != 4'hF);
        eg = (w >= 1 && oe_x[w-1] != 0) || (v && (~m != 4'h0));
      end
      chk(viol_mask_o == em, "R8 mask lead flag", 32'(viol_mask_o), 32'(em));
      chk(viol_gap_o == eg, "R9 gap flag", 32'(viol_gap_o), 32'(eg));
    end
  endtask

  initial begin
    for (int cl = 1; cl <= 3; cl++) begin
      run(cl, 0, "R1 R3 R4 len1");
      run(cl, 1, "R2 len2");
      run(cl, 2, "R2 len4");
      run(cl, 3, "R2 len8");
      run(cl, 4, "R2 reserved code");
      run(cl, 5, "R6 full page precharge");
      run(cl, 6, "R5 read interrupt");
      run(cl, 7, "R7 write after drain");
      run(cl, 8, "R7 write no mask");
      run(cl, 9, "R7 write proper lead");
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule